// File: doc/BRIEF.md
# MIDI Note Message Decoder

This block sits behind a serial byte receiver and turns its byte stream into note events. Each byte arrives with a one-cycle valid strobe. The block sorts bytes by their top bit into status bytes and data bytes. It follows the status, note, velocity order of a channel message. When a Note On or Note Off message completes, it latches the 7-bit note number onto a display register.

The velocity, the note-on/off flag and the 4-bit channel of the same message are latched with it. A one-cycle done strobe marks each update. Other status bytes stop data capture until the next note status arrives. After a complete note message, further data pairs reuse the last note status, which is known as running status.

Top module: `midi_note_decoder`

## Requirements
- R1: While reset is low and after its release, before any message completes, noteOut, velocityOut, channelOut, noteIsOn and msgDone are all zero.
- R2: A valid byte with bit 7 equal to 1 is a status byte. A valid byte with bit 7 equal to 0 is a data byte. Only a data byte can complete a message.
- R3: A status byte with upper nibble 0x9, then two data bytes, sets noteOut to bits 6:0 of the first data byte and velocityOut to bits 6:0 of the second. It also sets noteIsOn to 1 and channelOut to the status lower nibble.
- R4: The same sequence with status upper nibble 0x8 produces the same fields with noteIsOn equal to 0.
- R5: The outputs change only in the cycle after the velocity byte of a note message is accepted. A status byte or a note byte alone leaves them unchanged.
- R6: msgDone is high for exactly one cycle, in the cycle after each completing velocity byte is accepted.
- R7: A status byte that arrives mid-message discards the partial message, and the next data byte is taken as a note number.
- R8: After a complete note message, each further pair of data bytes forms a new message with the last note status and channel (running status).
- R9: Data bytes received after reset and before any status byte are ignored.
- R10: After a status byte whose upper nibble is neither 0x8 nor 0x9, data bytes are ignored until a note status byte arrives.
- R11: byteData is ignored in any cycle where byteValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | One-cycle strobe qualifying byteData |
| byteData | input | 8 | Received byte |
| noteOut | output | 7 | Note number of the last completed note message |
| velocityOut | output | 7 | Velocity of the last completed note message |
| channelOut | output | 4 | Channel of the last completed note message |
| noteIsOn | output | 1 | 1 for Note On, 0 for Note Off |
| msgDone | output | 1 | One-cycle strobe when the outputs update |

## Verification
The bench builds the block with its default 8-bit byte width. With this width, the status code is the upper nibble, the channel is the lower nibble, and every one of the 128 note values can be driven. Random streams mix note statuses on all channels, control and system status bytes, and runs of data bytes. These streams reach running-status chains, status bytes that interrupt a message, and data bytes sent while capture is stopped. The bench also leaves idle gaps between bytes while garbage sits on byteData.

// File: rtl/midi_dec_pkg.sv
package midi_dec_pkg;

  localparam logic [3:0] CODE_NOTE_ON  = 4'h9;
  localparam logic [3:0] CODE_NOTE_OFF = 4'h8;

  typedef enum logic [1:0] {
    SEQ_IGNORE   = 2'd0,
    SEQ_WANT_KEY = 2'd1,
    SEQ_WANT_VEL = 2'd2
  } seqState_t;

  typedef struct packed {
    logic loadStatus;
    logic statusIsOn;
    logic loadKey;
    logic commit;
  } dpStrobes_t;

endpackage

// File: rtl/midi_dec_ctrl.sv
module midi_dec_ctrl
  import midi_dec_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [CODE_W-1:0] topCode,
  output dpStrobes_t        strobes
);

  seqState_t state, stateNext;
  logic isStatus, isData, isNoteStatus;

  always_comb begin
    isStatus     = byteValid && topCode[CODE_W-1];
    isData       = byteValid && !topCode[CODE_W-1];
    isNoteStatus = isStatus &&
                   ((topCode == CODE_W'(CODE_NOTE_ON)) || (topCode == CODE_W'(CODE_NOTE_OFF)));

    strobes.loadStatus = isNoteStatus;
    strobes.statusIsOn = (topCode == CODE_W'(CODE_NOTE_ON));
    strobes.loadKey    = isData && (state == SEQ_WANT_KEY);
    strobes.commit     = isData && (state == SEQ_WANT_VEL);

    stateNext = state;
    if (isStatus)
      stateNext = isNoteStatus ? SEQ_WANT_KEY : SEQ_IGNORE;
    else if (strobes.loadKey)
      stateNext = SEQ_WANT_VEL;
    else if (strobes.commit)
      stateNext = SEQ_WANT_KEY;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IGNORE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/midi_dec_datapath.sv
module midi_dec_datapath
  import midi_dec_pkg::*;
#(
  parameter int PAY_W  = 7,
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [PAY_W-1:0]  payload,
  output logic [PAY_W-1:0]  noteOut,
  output logic [PAY_W-1:0]  velocityOut,
  output logic [CHAN_W-1:0] channelOut,
  output logic              noteIsOn,
  output logic              msgDone
);

  logic              pendIsOn;
  logic [CHAN_W-1:0] pendChan;
  logic [PAY_W-1:0]  pendKey;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendIsOn <= 1'b0;
      pendChan <= '0;
      pendKey  <= '0;
    end else begin
      if (strobes.loadStatus) begin
        pendIsOn <= strobes.statusIsOn;
        pendChan <= payload[CHAN_W-1:0];
      end
      if (strobes.loadKey) pendKey <= payload;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      noteOut     <= '0;
      velocityOut <= '0;
      channelOut  <= '0;
      noteIsOn    <= 1'b0;
      msgDone     <= 1'b0;
    end else begin
      msgDone <= strobes.commit;
      if (strobes.commit) begin
        noteOut     <= pendKey;
        velocityOut <= payload;
        channelOut  <= pendChan;
        noteIsOn    <= pendIsOn;
      end
    end
  end

endmodule

// File: rtl/midi_note_decoder.sv
module midi_note_decoder
  import midi_dec_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                byteValid,
  input  logic [BYTE_W-1:0]   byteData,
  output logic [BYTE_W-2:0]   noteOut,
  output logic [BYTE_W-2:0]   velocityOut,
  output logic [BYTE_W/2-1:0] channelOut,
  output logic                noteIsOn,
  output logic                msgDone
);

  localparam int PAY_W  = BYTE_W - 1;
  localparam int CODE_W = BYTE_W / 2;
  localparam int CHAN_W = BYTE_W - CODE_W;

  dpStrobes_t strobes;

  midi_dec_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .byteValid(byteValid),
    .topCode  (byteData[BYTE_W-1 -: CODE_W]),
    .strobes  (strobes)
  );

  midi_dec_datapath #(.PAY_W(PAY_W), .CHAN_W(CHAN_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .payload    (byteData[PAY_W-1:0]),
    .noteOut    (noteOut),
    .velocityOut(velocityOut),
    .channelOut (channelOut),
    .noteIsOn   (noteIsOn),
    .msgDone    (msgDone)
  );

endmodule

// File: rtl/midi_note_decoder_chk.sv
module midi_note_decoder_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                byteValid,
  input logic [BYTE_W-1:0]   byteData,
  input logic [BYTE_W-2:0]   noteOut,
  input logic [BYTE_W-2:0]   velocityOut,
  input logic [BYTE_W/2-1:0] channelOut,
  input logic                noteIsOn,
  input logic                msgDone
);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    msgDone |=> !msgDone);

  assert_hold_outputs_R5: assert property (@(posedge clk) disable iff (!rstN)
    !msgDone |-> ($stable(noteOut) && $stable(velocityOut) &&
                  $stable(channelOut) && $stable(noteIsOn)));

  assert_done_after_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    msgDone |-> ($past(byteValid) && !$past(byteData[BYTE_W-1])));

  assert_velocity_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
    msgDone |-> (velocityOut == $past(byteData[BYTE_W-2:0])));

  assert_idle_no_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |=> !msgDone);

endmodule

bind midi_note_decoder midi_note_decoder_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
  .noteOut(noteOut), .velocityOut(velocityOut), .channelOut(channelOut),
  .noteIsOn(noteIsOn), .msgDone(msgDone)
);

// File: tb/midi_note_decoder_tb.sv
`timescale 1ns/1ps
module midi_note_decoder_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic [6:0] noteOut, velocityOut;
  logic [3:0] channelOut;
  logic       noteIsOn, msgDone;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model
  int         mState = 0; // 0 ignore, 1 want key, 2 want velocity
  bit         mPendOn = 0;
  logic [3:0] mPendChan = 0;
  logic [6:0] mPendKey = 0;
  logic [6:0] eNote = 0, eVel = 0;
  logic [3:0] eChan = 0;
  bit         eOn = 0, eDone = 0;

  always #10 clk = ~clk;

  midi_note_decoder u_dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .noteOut(noteOut), .velocityOut(velocityOut), .channelOut(channelOut),
    .noteIsOn(noteIsOn), .msgDone(msgDone)
  );

  function automatic logic [19:0] packExp();
    return {eDone, eOn, eChan, eNote, eVel};
  endfunction

  function automatic void modelByte(logic [7:0] b);
    eDone = 0;
    if (b[7]) begin
      if (b[7:4] == 4'h9 || b[7:4] == 4'h8) begin
        mState = 1; mPendOn = (b[7:4] == 4'h9); mPendChan = b[3:0];
      end else mState = 0;
    end else if (mState == 1) begin
      mPendKey = b[6:0]; mState = 2;
    end else if (mState == 2) begin
      eNote = mPendKey; eVel = b[6:0]; eChan = mPendChan; eOn = mPendOn;
      eDone = 1; mState = 1;
    end
  endfunction

  task automatic checkNow(string tag);
    logic [19:0] act;
    act = {msgDone, noteIsOn, channelOut, noteOut, velocityOut};
    checks++;
    if (act !== packExp()) begin
      errors++;
      $display("FAIL %s: actual %05h expected %05h", tag, act, packExp());
    end
  endtask

  // drive at negedge, check at the next negedge (one register stage)
  task automatic sendByte(logic [7:0] b, string tag);
    @(negedge clk);
    byteValid = 1'b1; byteData = b;
    modelByte(b);
    @(negedge clk);
    byteValid = 1'b0; byteData = 8'($urandom);
    checkNow(tag);
    eDone = 0;
  endtask

  task automatic idleCycle(string tag);
    @(negedge clk);
    byteValid = 1'b0; byteData = 8'($urandom);
    @(negedge clk);
    checkNow(tag);
  endtask

  function automatic logic [7:0] randByte();
    int sel;
    sel = $urandom_range(0, 9);
    case (sel)
      0: return {4'h9, 4'($urandom)};
      1: return {4'h8, 4'($urandom)};
      2: return {4'hB, 4'($urandom)};
      3: return {4'hF, 4'($urandom)};
      default: return {1'b0, 7'($urandom)};
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    checkNow("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    checkNow("R1 after release");

    // R9: data before any status
    sendByte(8'h3C, "R9 stray data");
    sendByte(8'h40, "R9 stray data");
    sendByte(8'h41, "R9 stray data");

    // R3: note on, channel 5; R5: no change before velocity
    sendByte(8'h95, "R5 status only");
    sendByte(8'h3C, "R5 key only");
    sendByte(8'h64, "R3 note on complete");
    idleCycle("R6 done drops");

    // R8: running status
    sendByte(8'h7F, "R8 running key");
    sendByte(8'h01, "R8 running complete");

    // R4: note off channel 0xA
    sendByte(8'h8A, "R4 status");
    sendByte(8'h00, "R4 key");
    sendByte(8'h7F, "R4 note off complete");

    // R7: status mid-message
    sendByte(8'h92, "R7 status");
    sendByte(8'h11, "R7 key");
    sendByte(8'h83, "R7 interrupting status");
    sendByte(8'h22, "R7 new key");
    sendByte(8'h33, "R7 complete uses new key");

    // R10: non-note status stops capture
    sendByte(8'hB1, "R10 control status");
    sendByte(8'h10, "R10 ignored data");
    sendByte(8'h20, "R10 ignored data");
    sendByte(8'h30, "R10 ignored data");

    // R11: garbage with valid low mid-message
    sendByte(8'h9F, "R11 status");
    sendByte(8'h55, "R11 key");
    idleCycle("R11 invalid byte ignored");
    idleCycle("R11 invalid byte ignored");
    sendByte(8'h66, "R11 completes with real velocity");

    // R2: random stream classification
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 3) == 0) idleCycle("R11 random gap");
      sendByte(randByte(), "R2 random stream");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule